// File: doc/BRIEF.md
# Multiprocessor Bus Arbiter with Per-CPU Reset and Machine-Check Control

This block sits on a shared processor bus that serves up to four CPUs. It turns the CPUs' bus requests into a one-hot set of grants. It also drives an active-low hard reset, an active-low soft reset and an active-low machine-check line for each CPU. After reset it arbitrates between CPU 0 and CPU 1 only. CPUs 2 and 3 stay in reset and cannot win the bus until software sets one mode bit in the control register. That bit both widens arbitration to four requesters and takes CPUs 2 and 3 out of reset.

A small synchronous register port gives software five registers: control, hard reset, soft reset, processor ID and error pending. An external error detector delivers a single-cycle error pulse. The block charges that error to the CPU that holds the bus at that moment. Only two machine-check sources exist, so the four machine-check pins are driven in pairs: pins 0 and 2 share a source, and pins 1 and 3 share the other.

Top module: `mparb_ctrl`

## Requirements
- R1: While `rst` is high, all grants are low, every hard-reset and soft-reset output is low, and every machine-check output is high. After reset, CPUs 0 and 1 leave reset, CPUs 2 and 3 stay in reset, and every register reads 0.
- R2: In dual mode (control bit 17 = 0), only requesters 0 and 1 can be granted. Requests from 2 and 3 produce no grant.
- R3: Writing 1 to bit 17 of the control register (address 0) enables four-way mode, in which requesters 2 and 3 can be granted.
- R4: At most one grant is active at a time. A grant appears on the clock edge after the request is seen. It is held while its owner keeps requesting. When the bus is free, the next owner is the first requester found by counting upward from the last owner, wrapping around, among the eligible requesters.
- R5: While bit 17 is 0, the hard-reset and soft-reset outputs of CPUs 2 and 3 are driven low. Setting bit 17 releases them.
- R6: In the hard-reset register (address 1), bit 2+i set to 1 holds the hard reset of CPU i low: bit 4 controls CPU 2 and bit 5 controls CPU 3. The soft resets are unaffected.
- R7: In the soft-reset register (address 2), bit 2+i set to 1 holds the soft reset of CPU i low: bit 4 controls CPU 2 and bit 5 controls CPU 3. The hard resets are unaffected.
- R8: The processor-ID register (address 3) returns, in bits [7:0], the index of the most recently granted requester, from 0x00 to 0x03.
- R9: An error pulse while CPU 0 or CPU 1 holds the grant sets bit 0 or bit 1 of the error-pending register (address 4). Pending bit 0 drives machine-check pins 0 and 2 low. Pending bit 1 drives pins 1 and 3 low.
- R10: An error pulse while CPU 2 or CPU 3 holds the grant, or while no grant is active, records nothing.
- R11: Writing 1 to a bit of the error-pending register clears that bit. Writing 0 leaves it unchanged.
- R12: Bit 18 of the control register is readable and writable, resets to 0, and drives `ta_hold_high`.
- R13: Read data appears on the cycle after the address is presented. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 4 | Bus request, one bit per CPU |
| bus_gnt | output | 4 | One-hot bus grant |
| err_pulse | input | 1 | Single-cycle error indication |
| cpu_hrst_n | output | 4 | Active-low hard reset per CPU |
| cpu_srst_n | output | 4 | Active-low soft reset per CPU |
| cpu_mchk_n | output | 4 | Active-low machine check per CPU (paired) |
| ta_hold_high | output | 1 | Control bit 18, hold transfer acknowledge high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench issues all four requests at once in dual mode. A design that ignored the mode gating would grant CPU 2 or CPU 3 there. It then runs a full rotation in four-way mode, which exposes a wrong wrap-around or a grant taken away from an owner that is still requesting. Error pulses are charged to CPU 0, CPU 2, CPU 1 and to an idle bus. This catches a design that records errors for CPUs 2 and 3, that drives the wrong pin of a pair, or that clears a pending bit when 0 is written. Clearing the mode bit again must put CPUs 2 and 3 back into reset and must not disturb the register-controlled resets.

// File: rtl/mparb_pkg.sv
package mparb_pkg;
  // register map
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_HRST = 1;
  localparam int ADDR_SRST = 2;
  localparam int ADDR_PID  = 3;
  localparam int ADDR_ERR  = 4;
  // control register fields
  localparam int QUAD_BIT  = 17;
  localparam int TAH_BIT   = 18;
  // per-CPU reset bits start here: bit RST_BASE+i belongs to CPU i
  localparam int RST_BASE  = 2;
  // CPUs always eligible, also the number of machine-check sources
  localparam int BASE_CPUS = 2;
  localparam int PID_W     = 8;
endpackage

// File: rtl/mparb_rr_arbiter.sv
module mparb_rr_arbiter #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  elig,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] owner,
  output logic          busy
);
  logic          keep;
  logic          found;
  logic [IW-1:0] pick;

  assign busy = |gnt;
  assign keep = busy && req[owner] && elig[owner];

  always_comb begin
    int idx;
    found = 1'b0;
    pick  = owner;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(owner) + k) % N;
      if (!found && req[idx] && elig[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt   <= '0;
      owner <= '0;
    end else if (!keep) begin
      if (found) begin
        gnt   <= N'(1) << pick;
        owner <= pick;
      end else begin
        gnt   <= '0;
      end
    end
  end
endmodule

// File: rtl/mparb_regs.sv
module mparb_regs
  import mparb_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 32,
  parameter int AW = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [IW-1:0]        owner,
  input  logic                 busy,
  input  logic                 err_pulse,
  output logic [DW-1:0]        rdata,
  output logic                 quad_en,
  output logic                 ta_hold,
  output logic [N-1:0]         hrst_bits,
  output logic [N-1:0]         srst_bits,
  output logic [BASE_CPUS-1:0] mc_pend
);
  logic [BASE_CPUS-1:0] set_vec;
  logic [BASE_CPUS-1:0] clr_vec;
  logic [DW-1:0]        ctrl_word;
  logic                 wr_ctrl, wr_hrst, wr_srst, wr_err;

  assign wr_ctrl = we && (addr == AW'(ADDR_CTRL));
  assign wr_hrst = we && (addr == AW'(ADDR_HRST));
  assign wr_srst = we && (addr == AW'(ADDR_SRST));
  assign wr_err  = we && (addr == AW'(ADDR_ERR));

  always_comb begin
    for (int s = 0; s < BASE_CPUS; s++) begin
      set_vec[s] = err_pulse && busy && (int'(owner) == s);
    end
    clr_vec = wr_err ? wdata[BASE_CPUS-1:0] : '0;
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[QUAD_BIT] = quad_en;
    ctrl_word[TAH_BIT]  = ta_hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quad_en   <= 1'b0;
      ta_hold   <= 1'b0;
      hrst_bits <= '0;
      srst_bits <= '0;
      mc_pend   <= '0;
    end else begin
      if (wr_ctrl) begin
        quad_en <= wdata[QUAD_BIT];
        ta_hold <= wdata[TAH_BIT];
      end
      if (wr_hrst) hrst_bits <= wdata[RST_BASE +: N];
      if (wr_srst) srst_bits <= wdata[RST_BASE +: N];
      mc_pend <= (mc_pend & ~clr_vec) | set_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (int'(addr))
        ADDR_CTRL: rdata <= ctrl_word;
        ADDR_HRST: rdata[RST_BASE +: N] <= hrst_bits;
        ADDR_SRST: rdata[RST_BASE +: N] <= srst_bits;
        ADDR_PID:  rdata[PID_W-1:0] <= PID_W'(owner);
        ADDR_ERR:  rdata[BASE_CPUS-1:0] <= mc_pend;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mparb_ctrl.sv
module mparb_ctrl
  import mparb_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int DW    = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CPU-1:0] bus_req,
  output logic [N_CPU-1:0] bus_gnt,
  input  logic             err_pulse,
  output logic [N_CPU-1:0] cpu_hrst_n,
  output logic [N_CPU-1:0] cpu_srst_n,
  output logic [N_CPU-1:0] cpu_mchk_n,
  output logic             ta_hold_high,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata
);
  localparam int IW = (N_CPU > 1) ? $clog2(N_CPU) : 1;

  logic                 quad_en;
  logic                 ta_hold;
  logic [N_CPU-1:0]     elig;
  logic [N_CPU-1:0]     hrst_bits;
  logic [N_CPU-1:0]     srst_bits;
  logic [BASE_CPUS-1:0] mc_pend;
  logic [IW-1:0]        owner;
  logic                 busy;

  for (genvar g = 0; g < N_CPU; g++) begin : g_elig
    if (g < BASE_CPUS) begin : g_base
      assign elig[g] = 1'b1;
    end else begin : g_ext
      assign elig[g] = quad_en;
    end
  end

  mparb_rr_arbiter #(.N(N_CPU)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (bus_req),
    .elig  (elig),
    .gnt   (bus_gnt),
    .owner (owner),
    .busy  (busy)
  );

  mparb_regs #(.N(N_CPU), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .owner     (owner),
    .busy      (busy),
    .err_pulse (err_pulse),
    .rdata     (reg_rdata),
    .quad_en   (quad_en),
    .ta_hold   (ta_hold),
    .hrst_bits (hrst_bits),
    .srst_bits (srst_bits),
    .mc_pend   (mc_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_hrst_n   <= '0;
      cpu_srst_n   <= '0;
      cpu_mchk_n   <= '1;
      ta_hold_high <= 1'b0;
    end else begin
      ta_hold_high <= ta_hold;
      for (int i = 0; i < N_CPU; i++) begin
        cpu_hrst_n[i] <= ~(hrst_bits[i] | (~elig[i]));
        cpu_srst_n[i] <= ~(srst_bits[i] | (~elig[i]));
        cpu_mchk_n[i] <= ~mc_pend[i % BASE_CPUS];
      end
    end
  end
endmodule

// File: rtl/mparb_ctrl_chk.sv
module mparb_ctrl_chk #(
  parameter int N_CPU = 4,
  parameter int BASE  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [N_CPU-1:0] bus_req,
  input logic [N_CPU-1:0] bus_gnt,
  input logic             quad_en,
  input logic [N_CPU-1:0] cpu_hrst_n,
  input logic [N_CPU-1:0] cpu_srst_n
);
  // R4: never more than one grant
  p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_gnt));

  // R4: a grant always follows a request seen on the previous edge
  p_gnt_has_req_r4: assert property (@(posedge clk) disable iff (rst)
    (|bus_gnt) |-> (|($past(bus_req) & bus_gnt)));

  // R4: an eligible owner that keeps requesting keeps the bus
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((|(bus_gnt & bus_req)) && (quad_en || (|bus_gnt[BASE-1:0])))
      |=> (bus_gnt == $past(bus_gnt)));

  // R2: dual mode grants only the base requesters
  p_dual_only_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(quad_en) |-> (bus_gnt[N_CPU-1:BASE] == '0));

  // R5: extra CPUs held in reset while four-way mode is off
  p_ext_reset_r5: assert property (@(posedge clk) disable iff (rst)
    !quad_en |=> ((cpu_hrst_n[N_CPU-1:BASE] == '0) && (cpu_srst_n[N_CPU-1:BASE] == '0)));
endmodule

bind mparb_ctrl mparb_ctrl_chk #(.N_CPU(N_CPU), .BASE(mparb_pkg::BASE_CPUS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .quad_en    (quad_en),
  .cpu_hrst_n (cpu_hrst_n),
  .cpu_srst_n (cpu_srst_n)
);

// File: tb/mparb_ctrl_test.sv
module mparb_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_req = '0;
  logic [3:0]  bus_gnt;
  logic        err_pulse = 1'b0;
  logic [3:0]  cpu_hrst_n, cpu_srst_n, cpu_mchk_n;
  logic        ta_hold_high;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  mparb_ctrl uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .err_pulse(err_pulse), .cpu_hrst_n(cpu_hrst_n), .cpu_srst_n(cpu_srst_n),
    .cpu_mchk_n(cpu_mchk_n), .ta_hold_high(ta_hold_high), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 3'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse_err();
    err_pulse = 1'b1;
    @(negedge clk);
    err_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst = 1'b1;
    tick(3);
    chk("R1", "gnt in reset", 32'(bus_gnt), 32'h0);
    chk("R1", "hrst in reset", 32'(cpu_hrst_n), 32'h0);
    chk("R1", "srst in reset", 32'(cpu_srst_n), 32'h0);
    chk("R1", "mchk in reset", 32'(cpu_mchk_n), 32'hF);
    rst = 1'b0;
    tick(2);
    chk("R1", "hrst after reset", 32'(cpu_hrst_n), 32'h3);
    chk("R5", "srst after reset", 32'(cpu_srst_n), 32'h3);
    chk("R12", "ta_hold after reset", 32'(ta_hold_high), 32'h0);
    rd(0, d); chk("R1", "ctrl reg", d, 32'h0);
    rd(3, d); chk("R1", "pid reg", d, 32'h0);
    rd(4, d); chk("R1", "err reg", d, 32'h0);
  endtask

  task automatic t_dual();
    logic [31:0] d;
    bus_req = 4'b1111; tick(1);
    chk("R2", "dual all req", 32'(bus_gnt), 32'h2);
    rd(3, d); chk("R8", "pid owner 1", d, 32'h1);
    bus_req = 4'b1101; tick(1);
    chk("R4", "dual wrap to 0", 32'(bus_gnt), 32'h1);
    bus_req = 4'b1100; tick(2);
    chk("R2", "req 2/3 ignored", 32'(bus_gnt), 32'h0);
    rd(3, d); chk("R8", "pid keeps last", d, 32'h0);
  endtask

  task automatic t_quad();
    wr(0, 32'h0002_0000); tick(1);
    chk("R3", "quad grant 2", 32'(bus_gnt), 32'h4);
    chk("R5", "hrst released", 32'(cpu_hrst_n), 32'hF);
    chk("R5", "srst released", 32'(cpu_srst_n), 32'hF);
    bus_req = 4'b1111; tick(3);
    chk("R4", "hold while requesting", 32'(bus_gnt), 32'h4);
    bus_req = 4'b1011; tick(1);
    chk("R4", "rotate to 3", 32'(bus_gnt), 32'h8);
    bus_req = 4'b0111; tick(1);
    chk("R4", "wrap to 0", 32'(bus_gnt), 32'h1);
    bus_req = 4'b0110; tick(1);
    chk("R4", "rotate to 1", 32'(bus_gnt), 32'h2);
    bus_req = 4'b0000; tick(1);
    chk("R4", "release", 32'(bus_gnt), 32'h0);
  endtask

  task automatic t_err();
    logic [31:0] d;
    bus_req = 4'b0001; tick(1);
    chk("R4", "grant 0", 32'(bus_gnt), 32'h1);
    pulse_err();
    chk("R9", "mchk pair 0/2", 32'(cpu_mchk_n), 32'hA);
    rd(4, d); chk("R9", "pending 0", d, 32'h1);
    bus_req = 4'b0100; tick(1);
    chk("R4", "grant 2", 32'(bus_gnt), 32'h4);
    rd(3, d); chk("R8", "pid owner 2", d, 32'h2);
    pulse_err();
    rd(4, d); chk("R10", "owner 2 not recorded", d, 32'h1);
    chk("R10", "mchk unchanged", 32'(cpu_mchk_n), 32'hA);
    wr(4, 32'h0); rd(4, d); chk("R11", "write 0 keeps", d, 32'h1);
    wr(4, 32'h1); tick(1);
    rd(4, d); chk("R11", "w1c clears", d, 32'h0);
    chk("R11", "mchk cleared", 32'(cpu_mchk_n), 32'hF);
    bus_req = 4'b0010; tick(1);
    chk("R4", "grant 1", 32'(bus_gnt), 32'h2);
    pulse_err();
    chk("R9", "mchk pair 1/3", 32'(cpu_mchk_n), 32'h5);
    rd(4, d); chk("R9", "pending 1", d, 32'h2);
    wr(4, 32'h2);
    bus_req = 4'b0000; tick(1);
    pulse_err();
    rd(4, d); chk("R10", "idle bus not recorded", d, 32'h0);
    chk("R10", "mchk idle", 32'(cpu_mchk_n), 32'hF);
  endtask

  task automatic t_rst_regs();
    logic [31:0] d;
    wr(1, 32'h10); tick(1);
    chk("R6", "hard reset cpu2", 32'(cpu_hrst_n), 32'hB);
    chk("R6", "soft untouched", 32'(cpu_srst_n), 32'hF);
    rd(1, d); chk("R6", "hrst readback", d, 32'h10);
    wr(2, 32'h28); tick(1);
    chk("R7", "soft reset cpu3,cpu1", 32'(cpu_srst_n), 32'h5);
    chk("R7", "hard untouched", 32'(cpu_hrst_n), 32'hB);
    wr(1, 32'h0); wr(2, 32'h0);
    wr(0, 32'h0); tick(1);
    chk("R5", "hrst back in reset", 32'(cpu_hrst_n), 32'h3);
    chk("R5", "srst back in reset", 32'(cpu_srst_n), 32'h3);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] d;
    wr(0, 32'h0004_0000); tick(1);
    chk("R12", "ta_hold set", 32'(ta_hold_high), 32'h1);
    chk("R12", "quad still off", 32'(cpu_hrst_n), 32'h3);
    rd(0, d); chk("R12", "ctrl readback", d, 32'h0004_0000);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R13", "unused bits zero", d, 32'h0006_0000);
    rd(5, d); chk("R13", "unmapped addr", d, 32'h0);
    wr(0, 32'h0); tick(1);
    chk("R12", "ta_hold cleared", 32'(ta_hold_high), 32'h0);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_dual();
    t_quad();
    t_err();
    t_rst_regs();
    t_ctrl_bits();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule